// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block lives inside a small processor core, between the execution unit and the data memory. Each time the core reports that an instruction has finished, the block checks whether any interrupt source is pending. The sources are an instruction-raised exception, the overflow check, the bounds check, single-step, the non-maskable request, a coprocessor overrun, the maskable request and a software interrupt. If any source is pending, the block picks the most urgent one and runs the entry sequence on a word-wide request/acknowledge memory port. It saves the flags, clears the interrupt-enable and trap flags, saves the code segment and instruction pointer on the stack, then fetches the new pointer and segment from the vector table at address type × 4. It also runs the return sequence, which pops the pointer, the segment and the flags back off the stack.

The core hands the block the current flags, CS, IP, SS and SP when it asserts the boundary strobe or the return request. When `done` pulses, the core takes the new values from `flags_out`, `cs_out`, `ip_out` and `sp_out`. `busy` marks the whole sequence.

The sequencer has these states: IDLE, PUSH_FL, PUSH_CS, PUSH_IP, VEC_IP, VEC_CS, POP_IP, POP_CS, POP_FL and DONE. From IDLE it goes to POP_IP when `iret_req` is high. Otherwise it goes to PUSH_FL on `insn_done` with a pending source. Each memory state moves to the next one on `mem_ack`. The entry chain is PUSH_FL → PUSH_CS → PUSH_IP → VEC_IP → VEC_CS → DONE. The return chain is POP_IP → POP_CS → POP_FL → DONE. DONE goes back to IDLE after one cycle.

Top module: `intr_seq`

## Requirements
- R1: A sequence can start only in a cycle where `insn_done` or `iret_req` is high while the block is idle. Pending sources alone never raise `busy`.
- R2: At a boundary the block takes the first pending source in this order, which also gives its type:
  - `exc_req` (type `exc_type`)
  - overflow trap (type 4)
  - bounds trap (type 5)
  - single-step, when flag bit 8 (TF) is 1 (type 1)
  - `nmi_req` (type 2)
  - `cso_req` (type 9)
  - `intr_req` (type `intr_type`)
  - `swi_req` (type `swi_type`)
- R3: `intr_req` is ignored while flag bit 9 (IF) is 0. `nmi_req` is taken whatever the value of IF.
- R4: `ovf_chk` raises type 4 only when flag bit 11 (OF) is 1. With OF at 0 it raises nothing.
- R5: `bnd_chk` raises type 5 when `bnd_val` < `bnd_lo` or `bnd_val` > `bnd_hi`, compared as signed 16-bit values. No trap occurs when lo ≤ val ≤ hi.
- R6: The entry performs these memory accesses, in this order:
  - writes the flags at SS·16+SP−2
  - writes CS at SS·16+SP−4
  - writes IP at SS·16+SP−6
  - reads the new IP at type·4
  - reads the new CS at type·4+2

  `sp_out` ends as SP−6, `ip_out` and `cs_out` as the two words read.
- R7: The flags word written on entry is `flags_in` unchanged. `flags_out` after entry equals `flags_in` with bits 9 and 8 cleared.
- R8: The return (`iret_req`, which wins over a boundary in the same cycle) performs these memory accesses, in this order:
  - reads IP at SS·16+SP
  - reads CS at SS·16+SP+2
  - reads the flags at SS·16+SP+4

  `sp_out` ends as SP+6, and `flags_out` equals the popped word, so IF and TF take their saved values.
- R9: `busy` is high from the cycle after acceptance through the DONE cycle. No source is sampled while busy. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R10: `done` is high for exactly one cycle at the end of each sequence. `vec_type` gives the type taken, and types 32 to 255 pass unfiltered.
- R11: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe |
| iret_req | input | 1 | Start the return sequence |
| exc_req | input | 1 | Instruction-raised exception pending |
| exc_type | input | 8 | Type of that exception |
| ovf_chk | input | 1 | Overflow-check instruction finished |
| bnd_chk | input | 1 | Bounds-check instruction finished |
| bnd_val | input | 16 | Value under test |
| bnd_lo | input | 16 | Lower bound word |
| bnd_hi | input | 16 | Upper bound word |
| nmi_req | input | 1 | Non-maskable request |
| cso_req | input | 1 | Coprocessor segment overrun |
| intr_req | input | 1 | Maskable request |
| intr_type | input | 8 | Type supplied with the maskable request |
| swi_req | input | 1 | Software interrupt instruction |
| swi_type | input | 8 | Software interrupt type |
| flags_in | input | 16 | Current flags |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 16 | Write word |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 16 | Read word, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| vec_type | output | 8 | Type of the last entry |
| flags_out | output | 16 | New flags |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| sp_out | output | 16 | New stack pointer |

## Verification
The bench raises several sources together to test the priority order. If the arbiter were wrong, a lower source such as the maskable request would be taken ahead of NMI or single-step, and the wrong vector would be fetched. It tests the bounds check exactly at each limit and with a value whose sign bit is set. An unsigned or off-by-one compare would trap, or fail to trap, at those points. It also tests the overflow check with OF clear and the maskable request with IF clear, where a leaky mask would start a sequence. It holds the memory acknowledge back for varying times and strobes a new boundary while a sequence is busy. An early advance or a restart would then show up as an access out of order. On return, the popped flags must set IF and TF back to their saved values.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_VEC_IP,
        S_VEC_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_FL,
        S_DONE
    } seq_state_t;

    // flag bit positions
    localparam int FL_TF = 8;
    localparam int FL_IF = 9;
    localparam int FL_OF = 11;

    // fixed vector types
    localparam int VT_STEP = 1;
    localparam int VT_NMI  = 2;
    localparam int VT_OVF  = 4;
    localparam int VT_BND  = 5;
    localparam int VT_CSO  = 9;

endpackage

// File: rtl/intr_trap_eval.sv
module intr_trap_eval #(
    parameter int DW = 16
) (
    input  logic          ovf_chk,
    input  logic          of_flag,
    input  logic          bnd_chk,
    input  logic [DW-1:0] bnd_val,
    input  logic [DW-1:0] bnd_lo,
    input  logic [DW-1:0] bnd_hi,
    output logic          ovf_hit,
    output logic          bnd_hit
);
    logic below, above;

    always_comb begin
        below   = $signed(bnd_val) < $signed(bnd_lo);
        above   = $signed(bnd_val) > $signed(bnd_hi);
        ovf_hit = ovf_chk & of_flag;
        bnd_hit = bnd_chk & (below | above);
    end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          exc_req,
    input  logic [TW-1:0] exc_type,
    input  logic          ovf_hit,
    input  logic          bnd_hit,
    input  logic          step,
    input  logic          nmi_req,
    input  logic          cso_req,
    input  logic          intr_req,
    input  logic          int_en,
    input  logic [TW-1:0] intr_type,
    input  logic          swi_req,
    input  logic [TW-1:0] swi_type,
    output logic          hit,
    output logic [TW-1:0] hit_type
);
    localparam int NSRC = 8;

    logic [NSRC-1:0] src;
    logic [TW-1:0]   typ [NSRC];

    // index 0 is the most urgent source
    always_comb begin
        src    = {swi_req, intr_req & int_en, cso_req, nmi_req,
                  step, bnd_hit, ovf_hit, exc_req};
        typ[0] = exc_type;
        typ[1] = TW'(VT_OVF);
        typ[2] = TW'(VT_BND);
        typ[3] = TW'(VT_STEP);
        typ[4] = TW'(VT_NMI);
        typ[5] = TW'(VT_CSO);
        typ[6] = intr_type;
        typ[7] = swi_type;
    end

    always_comb begin
        hit      = 1'b0;
        hit_type = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (src[i]) begin
                hit      = 1'b1;
                hit_type = typ[i];
            end
        end
    end
endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 20,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_done,
    input  logic          iret_req,
    input  logic          hit,
    input  logic [TW-1:0] hit_type,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] cs_in,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] ss_in,
    input  logic [DW-1:0] sp_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [TW-1:0] vec_type,
    output logic [DW-1:0] flags_out,
    output logic [DW-1:0] cs_out,
    output logic [DW-1:0] ip_out,
    output logic [DW-1:0] sp_out
);
    localparam int            SEG_SH   = AW - DW;
    localparam int            VPAD     = AW - TW - 2;
    localparam logic [DW-1:0] WSTEP    = DW'(2);
    localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << FL_IF) | (DW'(1) << FL_TF));

    seq_state_t    state, nxt;
    logic [DW-1:0] r_fl, r_cs, r_ip, r_ss, r_sp;
    logic [TW-1:0] r_type;
    logic          r_entry;
    logic [AW-1:0] stk_addr, vec_addr;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (iret_req)              nxt = S_POP_IP;
                else if (insn_done && hit) nxt = S_PUSH_FL;
            end
            S_PUSH_FL: if (mem_ack) nxt = S_PUSH_CS;
            S_PUSH_CS: if (mem_ack) nxt = S_PUSH_IP;
            S_PUSH_IP: if (mem_ack) nxt = S_VEC_IP;
            S_VEC_IP:  if (mem_ack) nxt = S_VEC_CS;
            S_VEC_CS:  if (mem_ack) nxt = S_DONE;
            S_POP_IP:  if (mem_ack) nxt = S_POP_CS;
            S_POP_CS:  if (mem_ack) nxt = S_POP_FL;
            S_POP_FL:  if (mem_ack) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            r_fl    <= '0;
            r_cs    <= '0;
            r_ip    <= '0;
            r_ss    <= '0;
            r_sp    <= '0;
            r_type  <= '0;
            r_entry <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: begin
                    if (iret_req || (insn_done && hit)) begin
                        r_fl    <= flags_in;
                        r_cs    <= cs_in;
                        r_ip    <= ip_in;
                        r_ss    <= ss_in;
                        r_entry <= !iret_req;
                        r_sp    <= iret_req ? sp_in : sp_in - WSTEP;
                        if (!iret_req) r_type <= hit_type;
                    end
                end
                S_PUSH_FL: if (mem_ack) begin
                    r_fl <= r_fl & CLR_MASK;
                    r_sp <= r_sp - WSTEP;
                end
                S_PUSH_CS: if (mem_ack) r_sp <= r_sp - WSTEP;
                S_PUSH_IP: ;
                S_VEC_IP:  if (mem_ack) r_ip <= mem_rdata;
                S_VEC_CS:  if (mem_ack) r_cs <= mem_rdata;
                S_POP_IP: if (mem_ack) begin
                    r_ip <= mem_rdata;
                    r_sp <= r_sp + WSTEP;
                end
                S_POP_CS: if (mem_ack) begin
                    r_cs <= mem_rdata;
                    r_sp <= r_sp + WSTEP;
                end
                S_POP_FL: if (mem_ack) begin
                    r_fl <= mem_rdata;
                    r_sp <= r_sp + WSTEP;
                end
                S_DONE: ;
            endcase
        end
    end

    assign stk_addr = {r_ss, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, r_sp};
    assign vec_addr = {{VPAD{1'b0}}, r_type, 2'b00};

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = stk_addr;
        mem_wdata = '0;
        unique case (state)
            S_IDLE, S_DONE: ;
            S_PUSH_FL: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = r_fl; end
            S_PUSH_CS: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = r_cs; end
            S_PUSH_IP: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = r_ip; end
            S_VEC_IP:  begin mem_req = 1'b1; mem_addr = vec_addr; end
            S_VEC_CS:  begin mem_req = 1'b1; mem_addr = vec_addr | AW'(2); end
            S_POP_IP, S_POP_CS, S_POP_FL: mem_req = 1'b1;
        endcase
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        vec_type  = r_type;
        flags_out = r_fl;
        cs_out    = r_cs;
        ip_out    = r_ip;
        sp_out    = r_sp;
    end

    // R9: a pending access holds its request and contents until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: once busy, the block stays busy until its done cycle
    a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: with no boundary and no return request an idle block stays idle
    a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_done && !iret_req) |=> !busy);

    // R7: after an entry the enable and trap flags are clear
    a_r7_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_entry) |-> (!flags_out[FL_IF] && !flags_out[FL_TF]));

    // R6: vector reads stay inside the 1024-byte table, word aligned
    a_r6_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && r_entry && busy) |-> (mem_addr < AW'(1024) && !mem_addr[0]));
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 20,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_done,
    input  logic          iret_req,
    input  logic          exc_req,
    input  logic [TW-1:0] exc_type,
    input  logic          ovf_chk,
    input  logic          bnd_chk,
    input  logic [DW-1:0] bnd_val,
    input  logic [DW-1:0] bnd_lo,
    input  logic [DW-1:0] bnd_hi,
    input  logic          nmi_req,
    input  logic          cso_req,
    input  logic          intr_req,
    input  logic [TW-1:0] intr_type,
    input  logic          swi_req,
    input  logic [TW-1:0] swi_type,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] cs_in,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] ss_in,
    input  logic [DW-1:0] sp_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [TW-1:0] vec_type,
    output logic [DW-1:0] flags_out,
    output logic [DW-1:0] cs_out,
    output logic [DW-1:0] ip_out,
    output logic [DW-1:0] sp_out
);
    logic          ovf_hit, bnd_hit, hit;
    logic [TW-1:0] hit_type;

    intr_trap_eval #(.DW(DW)) u_trap (
        .ovf_chk (ovf_chk),
        .of_flag (flags_in[FL_OF]),
        .bnd_chk (bnd_chk),
        .bnd_val (bnd_val),
        .bnd_lo  (bnd_lo),
        .bnd_hi  (bnd_hi),
        .ovf_hit (ovf_hit),
        .bnd_hit (bnd_hit)
    );

    intr_arbiter #(.TW(TW)) u_arb (
        .exc_req   (exc_req),
        .exc_type  (exc_type),
        .ovf_hit   (ovf_hit),
        .bnd_hit   (bnd_hit),
        .step      (flags_in[FL_TF]),
        .nmi_req   (nmi_req),
        .cso_req   (cso_req),
        .intr_req  (intr_req),
        .int_en    (flags_in[FL_IF]),
        .intr_type (intr_type),
        .swi_req   (swi_req),
        .swi_type  (swi_type),
        .hit       (hit),
        .hit_type  (hit_type)
    );

    intr_seq_fsm #(.DW(DW), .AW(AW), .TW(TW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .iret_req  (iret_req),
        .hit       (hit),
        .hit_type  (hit_type),
        .flags_in  (flags_in),
        .cs_in     (cs_in),
        .ip_in     (ip_in),
        .ss_in     (ss_in),
        .sp_in     (sp_in),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .vec_type  (vec_type),
        .flags_out (flags_out),
        .cs_out    (cs_out),
        .ip_out    (ip_out),
        .sp_out    (sp_out)
    );

    // R3: a lone maskable request with IF clear starts nothing
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !iret_req && intr_req && !flags_in[FL_IF] && !flags_in[FL_TF]
         && !exc_req && !ovf_chk && !bnd_chk && !nmi_req && !cso_req && !swi_req) |=> !busy);

    // R4: overflow check with OF set is taken as type 4 ahead of all later sources
    a_r4_ovf_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !iret_req && ovf_chk && flags_in[FL_OF] && !exc_req)
        |=> (busy && vec_type == TW'(VT_OVF)));

    // R5: an in-range bounds check alone starts nothing
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !iret_req && bnd_chk && !flags_in[FL_TF]
         && $signed(bnd_val) >= $signed(bnd_lo) && $signed(bnd_val) <= $signed(bnd_hi)
         && !exc_req && !ovf_chk && !nmi_req && !cso_req && !intr_req && !swi_req) |=> !busy);
endmodule

// File: tb/test_intr_seq.sv
module test_intr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, iret_req = 1'b0;
    logic        exc_req = 1'b0, ovf_chk = 1'b0, bnd_chk = 1'b0;
    logic [7:0]  exc_type = 8'h00, intr_type = 8'h00, swi_type = 8'h00;
    logic [15:0] bnd_val = '0, bnd_lo = '0, bnd_hi = '0;
    logic        nmi_req = 1'b0, cso_req = 1'b0, intr_req = 1'b0, swi_req = 1'b0;
    logic [15:0] flags_in = 16'h0202, cs_in = 16'h1234, ip_in = 16'h5678;
    logic [15:0] ss_in = 16'h2000, sp_in = 16'h0100;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        busy, done;
    logic [7:0]  vec_type;
    logic [15:0] flags_out, cs_out, ip_out, sp_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    intr_seq i_intr_seq (.*);

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model
    logic [15:0] mem [int];
    function automatic logic [15:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // expected access list
    bit          q_we[$];
    int          q_addr[$];
    logic [15:0] q_wd[$];
    string       q_req[$];
    int          wait_len = 0;
    int          wait_cnt = 0;

    task automatic expect_acc(input bit we, input int addr, input logic [15:0] wd, input string req);
        q_we.push_back(we);
        q_addr.push_back(addr);
        q_wd.push_back(wd);
        q_req.push_back(req);
    endtask

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < wait_len) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                wait_len = (wait_len + 1) % 3;
                mem_ack  = 1'b1;
                if (q_addr.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9 unexpected access: actual=%0h expected=none", mem_addr);
                end else begin
                    automatic string rq = q_req.pop_front();
                    automatic bit    ew = q_we.pop_front();
                    automatic int    ea = q_addr.pop_front();
                    automatic logic [15:0] ed = q_wd.pop_front();
                    check(rq, "access dir", mem_we, ew);
                    check(rq, "access addr", mem_addr, ea);
                    if (ew) check(rq, "write word", mem_wdata, ed);
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                else        mem_rdata = mem_rd(int'(mem_addr));
            end
        end
    end

    // behavioural choice of source
    task automatic model_pick(output bit hit, output logic [7:0] t);
        hit = 1'b1;
        if (exc_req)                                   t = exc_type;
        else if (ovf_chk && flags_in[11])              t = 8'd4;
        else if (bnd_chk && ($signed(bnd_val) < $signed(bnd_lo) ||
                             $signed(bnd_val) > $signed(bnd_hi))) t = 8'd5;
        else if (flags_in[8])                          t = 8'd1;
        else if (nmi_req)                              t = 8'd2;
        else if (cso_req)                              t = 8'd9;
        else if (intr_req && flags_in[9])              t = intr_type;
        else if (swi_req)                              t = swi_type;
        else begin hit = 1'b0; t = 8'h00; end
    endtask

    task automatic clear_src();
        exc_req = 1'b0; ovf_chk = 1'b0; bnd_chk = 1'b0; nmi_req = 1'b0;
        cso_req = 1'b0; intr_req = 1'b0; swi_req = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            check(req, "busy during sequence", busy, 1'b1);
            n++;
        end
        check(req, "done reached", done, 1'b1);
    endtask

    task automatic boundary(input string req, input bit poke);
        bit          hit;
        logic [7:0]  t;
        int          base;
        logic [15:0] fl0;
        base = int'(ss_in) * 16;
        fl0  = flags_in;
        @(negedge clk);
        insn_done = 1'b1;
        model_pick(hit, t);
        if (hit) begin
            expect_acc(1'b1, base + int'(sp_in) - 2, fl0,   "R7");
            expect_acc(1'b1, base + int'(sp_in) - 4, cs_in, "R6");
            expect_acc(1'b1, base + int'(sp_in) - 6, ip_in, "R6");
            expect_acc(1'b0, int'(t) * 4,     16'h0, "R6");
            expect_acc(1'b0, int'(t) * 4 + 2, 16'h0, "R6");
        end
        @(negedge clk);
        insn_done = 1'b0;
        clear_src();
        if (!hit) begin
            for (int k = 0; k < 3; k++) begin
                check(req, "no sequence busy", busy, 1'b0);
                check(req, "no sequence mem_req", mem_req, 1'b0);
                @(negedge clk);
            end
            return;
        end
        check("R9", "busy after accept", busy, 1'b1);
        if (poke) begin
            insn_done = 1'b1; nmi_req = 1'b1;
            @(negedge clk);
            insn_done = 1'b0; nmi_req = 1'b0;
        end
        wait_done(req);
        check(req,   "vec_type", vec_type, t);
        check("R6",  "ip_out", ip_out, mem_rd(int'(t) * 4));
        check("R6",  "cs_out", cs_out, mem_rd(int'(t) * 4 + 2));
        check("R6",  "sp_out", sp_out, sp_in - 16'd6);
        check("R7",  "flags_out", flags_out, fl0 & 16'hFCFF);
        check("R6",  "all accesses made", q_addr.size(), 0);
        @(negedge clk);
        check("R10", "done one cycle", done, 1'b0);
        check("R9",  "idle after done", busy, 1'b0);
    endtask

    task automatic do_return(input logic [15:0] sp, input logic [15:0] ipw,
                             input logic [15:0] csw, input logic [15:0] flw);
        int base;
        base = int'(ss_in) * 16;
        sp_in = sp;
        mem[base + int'(sp)]     = ipw;
        mem[base + int'(sp) + 2] = csw;
        mem[base + int'(sp) + 4] = flw;
        expect_acc(1'b0, base + int'(sp),     16'h0, "R8");
        expect_acc(1'b0, base + int'(sp) + 2, 16'h0, "R8");
        expect_acc(1'b0, base + int'(sp) + 4, 16'h0, "R8");
        @(negedge clk);
        iret_req = 1'b1; insn_done = 1'b1; nmi_req = 1'b1;
        @(negedge clk);
        iret_req = 1'b0; insn_done = 1'b0; nmi_req = 1'b0;
        check("R8", "busy after return", busy, 1'b1);
        wait_done("R8");
        check("R8", "ip_out", ip_out, ipw);
        check("R8", "cs_out", cs_out, csw);
        check("R8", "flags_out", flags_out, flw);
        check("R8", "sp_out", sp_out, sp + 16'd6);
        check("R8", "all pops made", q_addr.size(), 0);
        @(negedge clk);
        sp_in = 16'h0100;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset busy", busy, 1'b0);
        check("R11", "reset done", done, 1'b0);
        check("R11", "reset mem_req", mem_req, 1'b0);

        // R1: pending request without a boundary
        nmi_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1", "idle without boundary", busy, 1'b0);
        end
        nmi_req = 1'b0;

        // R10: maskable request with a user type
        intr_req = 1'b1; intr_type = 8'h40;
        boundary("R10", 1'b0);

        // R3: masked maskable request, then NMI with IF clear
        flags_in = 16'h0002;
        intr_req = 1'b1; intr_type = 8'h41;
        boundary("R3", 1'b0);
        nmi_req = 1'b1; intr_req = 1'b1;
        boundary("R3", 1'b0);
        flags_in = 16'h0202;

        // R2: priority order
        exc_req = 1'b1; exc_type = 8'h00; ovf_chk = 1'b1; nmi_req = 1'b1;
        intr_req = 1'b1; swi_req = 1'b1; swi_type = 8'h21;
        boundary("R2", 1'b0);
        flags_in = 16'h0302;
        nmi_req = 1'b1; intr_req = 1'b1;
        boundary("R2", 1'b0);
        flags_in = 16'h0202;
        nmi_req = 1'b1; cso_req = 1'b1;
        boundary("R2", 1'b0);
        cso_req = 1'b1; intr_req = 1'b1; intr_type = 8'h50;
        boundary("R2", 1'b0);
        intr_req = 1'b1; intr_type = 8'h60; swi_req = 1'b1; swi_type = 8'h80;
        boundary("R2", 1'b0);
        swi_req = 1'b1; swi_type = 8'hFF;
        boundary("R10", 1'b0);

        // R4: overflow check
        ovf_chk = 1'b1;
        boundary("R4", 1'b0);
        flags_in = 16'h0A02;
        ovf_chk = 1'b1; nmi_req = 1'b1;
        boundary("R4", 1'b0);
        flags_in = 16'h0202;

        // R5: bounds check, signed, at each limit
        bnd_lo = 16'hFFFD; bnd_hi = 16'd10;
        bnd_chk = 1'b1; bnd_val = 16'hFFFB;
        boundary("R5", 1'b0);
        bnd_chk = 1'b1; bnd_val = 16'hFFFD;
        boundary("R5", 1'b0);
        bnd_chk = 1'b1; bnd_val = 16'd10;
        boundary("R5", 1'b0);
        bnd_chk = 1'b1; bnd_val = 16'd11;
        boundary("R5", 1'b0);
        bnd_lo = 16'd0; bnd_hi = 16'd100;
        bnd_chk = 1'b1; bnd_val = 16'h8000;
        boundary("R5", 1'b0);

        // R9: new boundary strobed while busy
        nmi_req = 1'b1;
        boundary("R9", 1'b1);

        // R8: return restores IF and TF from the stack
        flags_in = 16'h0002;
        do_return(16'h0080, 16'hBEEF, 16'hCAFE, 16'h0302);
        do_return(16'h0040, 16'h1111, 16'h2222, 16'h0800);
        flags_in = 16'h0202;

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule